// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog counter that cannot be switched off. It counts a synchronous low-speed tick enable, sampled in the system clock domain. When the count reaches the end of the selected period without software having serviced it, the block raises a one-cycle reset request for the chip's reset controller. Software reaches the block through a write-only byte port with two registers. A mode register at address 0 chooses the period. A restart register at address 1 clears the count, but only when the correct key byte is written to it.

The watchdog is a guard against runaway code, so the block treats any write that looks wrong as a fault. A wrong key byte raises the reset request. A second write to the mode register after reset also raises it. The stop-mode input is accepted at the port but has no influence on counting. Any servicing during stop mode has to come from another timer.

Top module: `keyed_wdt`

## Requirements
- R1: While `rst_n` is low and immediately after its release, `rst_req` is low, the count is zero, the mode lock is clear and the period code is 3'b111, which gives 2^(MIN_EXP+7) ticks (2^18 with defaults).
- R2: A write to address 0 takes bits [2:0] as the period code; code n selects a period of 2^(MIN_EXP+n) ticks (MIN_EXP defaults to 11).
- R3: Writing 8'hAC to address 1 clears the count to zero, and counting resumes from zero on the next tick.
- R4: Every write to address 0, accepted or not, clears the count to zero.
- R5: Bits [4:3] of a mode write have no effect on the period.
- R6: `stop_mode` has no effect: the count advances on every tick whatever its level.
- R7: A tick that arrives while the count is at period-1, with no clearing write in that cycle, raises `rst_req` in the next cycle and wraps the count to zero, starting a new period.
- R8: Writing any byte other than 8'hAC to address 1 raises `rst_req` in the next cycle and leaves the count alone.
- R9: Only the first write to address 0 after reset sets the period code. Any later write leaves the code unchanged and raises `rst_req` in the next cycle.
- R10: `rst_req` is high for exactly one cycle. An event in the cycle right after a pulse is merged into that pulse.
- R11: The count changes only in cycles where `lo_tick` is high or a clearing write occurs.
- R12: When a clearing write coincides with the terminal tick, the clear wins: no request is raised and the count becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 1 | Register select: 0 mode, 1 restart key |
| wr_data | input | DATA_W | Write data byte |
| lo_tick | input | 1 | Low-speed tick enable, synchronous to clk |
| stop_mode | input | 1 | Stop-mode indication, has no effect on counting |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The bench builds the block with CNT_W=10 and MIN_EXP=3. This keeps the eight periods at 8 to 1024 ticks, so the power-on period and several back-to-back timeouts of other periods all finish in a few thousand cycles. It also selects the table variant of the period decoder (TERM_IMPL=1), while the default shift variant is covered by the default elaboration. Holding `lo_tick` high makes every timeout land on a predictable cycle. That lets the bench place a key write exactly on the terminal tick, and measure a gated gap in the tick stream as a delay of the same length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // register select on the one-bit write address
   typedef enum logic {
      WDT_REG_MODE = 1'b0,
      WDT_REG_KEY  = 1'b1
   } wdt_reg_e;

   // events decoded from one bus write
   typedef struct packed {
      logic clr;   // restart the count
      logic viol;  // protocol violation, request reset
   } wdt_evt_t;

   localparam logic [7:0] WDT_KEY_DEFAULT = 8'hAC;

   // period decoder variants
   localparam int WDT_TERM_SHIFT = 0;
   localparam int WDT_TERM_TABLE = 1;

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
   import wdt_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter int                SEL_W  = 3,
   parameter logic [DATA_W-1:0] KEY    = DATA_W'(WDT_KEY_DEFAULT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEL_W-1:0]  sel,
   output logic              locked,
   output wdt_evt_t          evt
);

   logic mode_wr;
   logic key_wr;
   logic key_ok;

   assign mode_wr = wr_en && (wdt_reg_e'(wr_addr) == WDT_REG_MODE);
   assign key_wr  = wr_en && (wdt_reg_e'(wr_addr) == WDT_REG_KEY);
   assign key_ok  = (wr_data == KEY);

   always_comb begin
      evt.clr  = mode_wr | (key_wr & key_ok);
      evt.viol = (mode_wr & locked) | (key_wr & ~key_ok);
   end

   // period code: written once, then frozen until reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel    <= '1;
         locked <= 1'b0;
      end else if (mode_wr && !locked) begin
         sel    <= wr_data[SEL_W-1:0];
         locked <= 1'b1;
      end
   end

endmodule

// File: rtl/wdt_term.sv
module wdt_term
   import wdt_pkg::*;
#(
   parameter int CNT_W     = 18,
   parameter int SEL_W     = 3,
   parameter int MIN_EXP   = 11,
   parameter int TERM_IMPL = WDT_TERM_SHIFT
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] term
);

   localparam int NCODES = 1 << SEL_W;

   if (TERM_IMPL == WDT_TERM_TABLE) begin : g_table
      logic [CNT_W-1:0] tab [NCODES];
      for (genvar gi = 0; gi < NCODES; gi++) begin : g_ent
         assign tab[gi] = CNT_W'((64'd1 << (MIN_EXP + gi)) - 64'd1);
      end
      assign term = tab[sel];
   end else begin : g_shift
      logic [CNT_W:0] pw;
      assign pw   = (CNT_W+1)'(1) << (MIN_EXP + int'(sel));
      assign term = CNT_W'(pw - (CNT_W+1)'(1));
   end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] term,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic at_term;

   assign at_term = (cnt == term);
   assign wrap    = tick & ~clr & at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= at_term ? '0 : cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                SEL_W     = 3,
   parameter int                MIN_EXP   = 11,
   parameter int                CNT_W     = 18,
   parameter int                TERM_IMPL = WDT_TERM_SHIFT,
   parameter logic [DATA_W-1:0] KEY       = DATA_W'(WDT_KEY_DEFAULT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lo_tick,
   input  logic              stop_mode,
   output logic              rst_req
);

   localparam int MAX_EXP = MIN_EXP + (1 << SEL_W) - 1;

   if (MAX_EXP != CNT_W) begin : g_bad_width
      $error("keyed_wdt: CNT_W must equal MIN_EXP + 2**SEL_W - 1");
   end
   if (SEL_W < 1 || SEL_W > DATA_W) begin : g_bad_sel
      $error("keyed_wdt: SEL_W must lie in 1..DATA_W");
   end
   if (CNT_W > 63 || MIN_EXP < 1) begin : g_bad_exp
      $error("keyed_wdt: period exponents out of range");
   end
   if (TERM_IMPL != WDT_TERM_SHIFT && TERM_IMPL != WDT_TERM_TABLE) begin : g_bad_impl
      $error("keyed_wdt: unknown TERM_IMPL");
   end

   logic [SEL_W-1:0] sel;
   logic             locked;
   wdt_evt_t         evt;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic             req_q;

   // stop mode is deliberately not routed anywhere: the timer never halts
   logic unused_stop;
   assign unused_stop = stop_mode;

   wdt_regif #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .KEY    (KEY)
   ) u_regif (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sel     (sel),
      .locked  (locked),
      .evt     (evt)
   );

   wdt_term #(
      .CNT_W     (CNT_W),
      .SEL_W     (SEL_W),
      .MIN_EXP   (MIN_EXP),
      .TERM_IMPL (TERM_IMPL)
   ) u_term (
      .sel  (sel),
      .term (term)
   );

   wdt_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (lo_tick),
      .clr   (evt.clr),
      .term  (term),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   // single-cycle request; an event right after a pulse folds into it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         req_q <= req_q ? 1'b0 : (wrap | evt.viol);
      end
   end

   assign rst_req = req_q;

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
   parameter int                DATA_W = 8,
   parameter int                SEL_W  = 3,
   parameter int                CNT_W  = 18,
   parameter logic [DATA_W-1:0] KEY    = 8'hAC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              lo_tick,
   input logic              rst_req,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  term,
   input logic [SEL_W-1:0]  sel,
   input logic              locked
);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (cnt == '0) && (sel == '1) && !locked && !rst_req);

   assert_key_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr && (wr_data == KEY) |=> cnt == '0);

   assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_addr |=> cnt == '0);

   // R6: a tick always advances the count, stop mode notwithstanding
   assert_tick_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_tick && !wr_en && (cnt != term) |=> cnt == $past(cnt) + CNT_W'(1));

   assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lo_tick && !wr_en && (cnt == term) && !rst_req |=> rst_req && (cnt == '0));

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term);

   assert_bad_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr && (wr_data != KEY) && !rst_req |=> rst_req);

   assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_addr && locked |=> $stable(sel) && locked);

   assert_second_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_addr && locked && !rst_req |=> rst_req);

   assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_tick && !wr_en |=> $stable(cnt));

   assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lo_tick && wr_en && wr_addr && (wr_data == KEY) && (cnt == term)
      |=> !rst_req && (cnt == '0));

endmodule

bind keyed_wdt keyed_wdt_chk #(
   .DATA_W (DATA_W),
   .SEL_W  (SEL_W),
   .CNT_W  (CNT_W),
   .KEY    (KEY)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .lo_tick (lo_tick),
   .rst_req (rst_req),
   .cnt     (cnt),
   .term    (term),
   .sel     (sel),
   .locked  (locked)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;

   localparam int         DATA_W  = 8;
   localparam int         SEL_W   = 3;
   localparam int         MIN_EXP = 3;
   localparam int         CNT_W   = 10;
   localparam logic [7:0] KEY     = 8'hAC;
   localparam int         P_MAX   = 1 << CNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              wr_addr = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              lo_tick = 1'b1;
   logic              stop_mode = 1'b0;
   logic              rst_req;

   keyed_wdt #(
      .DATA_W    (DATA_W),
      .SEL_W     (SEL_W),
      .MIN_EXP   (MIN_EXP),
      .CNT_W     (CNT_W),
      .TERM_IMPL (1),
      .KEY       (KEY)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .lo_tick   (lo_tick),
      .stop_mode (stop_mode),
      .rst_req   (rst_req)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      string tag;
   } exp_t;

   exp_t  expq[$];
   int    vectors = 0;
   int    miscompares = 0;
   string phase = "R1";
   bit    done = 1'b0;

   // scoreboard insert, kept sorted by cycle
   task automatic push(input int at, input string tag);
      exp_t e;
      int   i;
      e.at  = at;
      e.tag = tag;
      i = 0;
      while (i < expq.size() && expq[i].at <= at) i++;
      expq.insert(i, e);
   endtask

   // monitor: compares rst_req against the expected pulse list
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (expq.size() > 0 && expq[0].at == cyc) begin
            vectors++;
            if (rst_req !== 1'b1) begin
               miscompares++;
               $display("FAIL %s: rst_req at cycle %0d actual %b expected 1",
                        expq[0].tag, cyc, rst_req);
            end
            void'(expq.pop_front());
         end else if (rst_req !== 1'b0) begin
            vectors++;
            miscompares++;
            $display("FAIL %s/R10: unexpected rst_req at cycle %0d actual %b expected 0",
                     phase, cyc, rst_req);
         end
      end
   end

   // driver: one bus write, pushing its predicted pulses
   task automatic wr_push(input logic a, input logic [7:0] d, input bit bad,
                          input int per, input int n, input string tag);
      int at;
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      at      = cyc;
      phase   = tag;
      if (bad) push(at + 1, tag);
      for (int k = 1; k <= n; k++) push(at + 1 + k * per, tag);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drain();
      while (expq.size() > 0) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL %s: watchdog expired actual running expected finished", phase);
      finish_run();
   end

   initial begin
      int a;
      int p;

      // R1: reset state
      repeat (3) @(negedge clk);
      vectors++;
      if (rst_req !== 1'b0) begin
         miscompares++;
         $display("FAIL R1: rst_req in reset actual %b expected 0", rst_req);
      end

      // R1: power-on period is the longest one
      @(negedge clk);
      rst_n = 1'b1;
      phase = "R1";
      push(cyc + P_MAX, "R1");
      drain();

      // R2/R5/R4: first mode write, code 3'b010 with bits 4:3 set -> 32 ticks
      wr_push(1'b0, 8'h1A, 1'b0, 32, 2, "R2_R5");
      drain();

      // R3: key restarts the count
      repeat (10) @(negedge clk);
      wr_push(1'b1, KEY, 1'b0, 32, 1, "R3");
      drain();

      // R8: wrong key requests reset without clearing the count
      wr_push(1'b1, KEY, 1'b0, 32, 1, "R3");
      repeat (5) @(negedge clk);
      wr_push(1'b1, 8'h53, 1'b1, 32, 0, "R8");
      drain();

      // R9: second mode write requests reset, clears, keeps the 32-tick code
      wr_push(1'b0, 8'h07, 1'b1, 32, 1, "R9");
      drain();

      // R6: stop mode does not pause the count
      stop_mode = 1'b1;
      wr_push(1'b1, KEY, 1'b0, 32, 2, "R6");
      drain();
      stop_mode = 1'b0;

      // R11: a 50-cycle gap in ticks delays the timeout by 50
      @(negedge clk);
      a = cyc;
      wr_push(1'b1, KEY, 1'b0, 32, 0, "R11");
      push(a + 1 + 1 + 32 + 50, "R11");
      repeat (10) @(negedge clk);
      lo_tick = 1'b0;
      repeat (50) @(negedge clk);
      lo_tick = 1'b1;
      drain();

      // R12: key on the terminal tick suppresses the request
      wr_push(1'b1, KEY, 1'b0, 32, 0, "R12");
      p = cyc;
      while (cyc < p + 30) @(negedge clk);
      wr_push(1'b1, KEY, 1'b0, 32, 1, "R12");
      drain();

      // R1: reset mid-run, then smallest period R2 and lock cleared
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         vectors++;
         if (rst_req !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: rst_req in reset actual %b expected 0", rst_req);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;
      wr_push(1'b0, 8'h00, 1'b0, 8, 3, "R2_R9");
      drain();

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule